// File: doc/BRIEF.md
# Strobed Parallel Byte-Queue Port

This block sits between an external host and an on-chip data path. The host sees an 8-bit parallel bus, two active-low strobes (one to read, one to write) and two active-low status flags. The host reads bytes that the upstream side has queued, and it writes bytes that the upstream side later drains. The host strobes have no relation to the system clock. Each strobe goes through a two-flop synchroniser, and the block then detects its edges.

Bytes from the upstream side enter the host-read queue through a valid/ready input. Bytes the host writes leave through a valid/ready output. A separate active-low strobe asks the upstream packetiser to send all buffered bytes at once, whatever the packet size. The block signals this as a one-cycle flush pulse. The bus pad itself is outside the block. The block gives out the drive value and a drive-enable.

Top module: `hostfifo_port`

## Requirements
- R1: `bus_oe` is high exactly while `rst_n` is high and `host_rd_n` is low. While it is high and the host-read queue is not empty, `bus_out` shows the oldest byte in that queue.
- R2: `avail_n` is low only when the host-read queue holds at least one byte, the block is out of reset and no hold-off window is running. Otherwise it is high.
- R3: A rise of `host_rd_n` removes the oldest byte of the host-read queue at the third rising clock edge that samples the pin high. A rise while the queue is empty removes nothing.
- R4: Every detected rise of `host_rd_n` starts a hold-off window. `avail_n` stays high for the two clock cycles that follow the edge at which the rise takes effect, even if bytes remain.
- R5: `space_n` is high while the host-write queue holds 16 bytes or the block is in reset. Otherwise it is low.
- R6: A fall of `host_wr_n` appends the value of `bus_in` to the host-write queue. The value is sampled at the third rising clock edge that samples the pin low.
- R7: A write that takes effect while the host-write queue holds 16 bytes is discarded. It sets `wr_overflow`, and only reset clears that bit.
- R8: A fall of `host_flush_n` makes `flush_req` high for exactly one clock cycle. The pulse starts after the second rising edge that samples the pin low.
- R9: In reset both queues are empty, `avail_n` and `space_n` are high, `bus_oe`, `flush_req` and `wr_overflow` are low.
- R10: `in_ready` is high while the host-read queue holds fewer than 16 bytes. A byte is appended at a clock edge where `in_valid` and `in_ready` are both high. Bytes leave in arrival order.
- R11: `out_valid` is high while the host-write queue is not empty, and `out_data` is its oldest byte. That byte leaves at an edge where `out_ready` is high. Bytes leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_flush_n | input | 1 | Host send-now strobe, active low, asynchronous |
| bus_in | input | 8 | Value seen on the parallel bus |
| bus_out | output | 8 | Value to drive on the parallel bus |
| bus_oe | output | 1 | Drive enable for the parallel bus |
| avail_n | output | 1 | Low when a byte may be read |
| space_n | output | 1 | Low when a byte may be written |
| wr_overflow | output | 1 | Sticky flag: a write was lost to a full queue |
| in_data | input | 8 | Byte from upstream into the host-read queue |
| in_valid | input | 1 | Upstream byte is valid |
| in_ready | output | 1 | Host-read queue can take a byte |
| out_data | output | 8 | Oldest byte of the host-write queue |
| out_valid | output | 1 | Host-write queue is not empty |
| out_ready | input | 1 | Upstream takes the byte |
| flush_req | output | 1 | One-cycle request to send buffered bytes now |

## Verification
`bus_oe` follows the read pin with no delay. A flush pulse starts two edges after the strobe's first low sample. Pops, writes and the start of the hold-off window land on the third edge. Upstream pushes and drains land on the edge where the handshake holds. The bench keeps its own two-stage delay line for each strobe and a queue per direction. It updates them at every rising edge and compares every output with them three quarters of a period later. Stimulus changes only at falling edges, so each result is sampled in the cycle where it becomes due.

// File: rtl/hostfifo_port.sv
module hostfifo_port #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int HOLD  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_flush_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          avail_n,
  output logic          space_n,
  output logic          wr_overflow,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          flush_req
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [2:0] rd_sh, wr_sh, fl_sh;
  logic rd_rise, wr_fall, fl_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sh <= '1;
      wr_sh <= '1;
      fl_sh <= '1;
    end else begin
      rd_sh <= {rd_sh[1:0], host_rd_n};
      wr_sh <= {wr_sh[1:0], host_wr_n};
      fl_sh <= {fl_sh[1:0], host_flush_n};
    end

  assign rd_rise   = rd_sh[1] & ~rd_sh[2];
  assign wr_fall   = ~wr_sh[1] & wr_sh[2];
  assign fl_fall   = ~fl_sh[1] & fl_sh[2];
  assign flush_req = fl_fall;

  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_rp, rx_wp;
  logic [CW-1:0] rx_cnt;
  logic [HW-1:0] hold;
  logic rx_push, rd_pop;

  assign in_ready = rx_cnt != FULL;
  assign rx_push  = in_valid & in_ready;
  assign rd_pop   = rd_rise & (rx_cnt != '0);

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= in_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_rp  <= '0;
      rx_wp  <= '0;
      rx_cnt <= '0;
      hold   <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rd_pop)  rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rd_pop);
      if (rd_rise)        hold <= HW'(HOLD);
      else if (hold != '0) hold <= hold - 1'b1;
    end

  assign bus_out = rx_mem[rx_rp];
  assign bus_oe  = rst_n & ~host_rd_n;
  assign avail_n = ~rst_n | (rx_cnt == '0) | (hold != '0);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp;
  logic [CW-1:0] tx_cnt;
  logic tx_push, tx_pop, tx_full;

  assign tx_full   = tx_cnt == FULL;
  assign tx_push   = wr_fall & ~tx_full;
  assign out_valid = tx_cnt != '0;
  assign tx_pop    = out_valid & out_ready;
  assign out_data  = tx_mem[tx_rp];
  assign space_n   = ~rst_n | tx_full;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_rp       <= '0;
      tx_wp       <= '0;
      tx_cnt      <= '0;
      wr_overflow <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (wr_fall & tx_full) wr_overflow <= 1'b1;
    end
endmodule

// File: rtl/hostfifo_port_chk.sv
module hostfifo_port_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out,
  input logic          avail_n,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rd_pop,
  input logic          wr_fall,
  input logic          wr_overflow,
  input logic          flush_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  assert_bus_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !rd_pop && rx_cnt != '0) |=> (!bus_oe || $stable(bus_out)));
  assert_empty_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> avail_n);
  assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> avail_n);
  assert_full_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fall && tx_cnt == CW'(DEPTH)) |=> wr_overflow);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overflow |=> wr_overflow);
  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);
  assert_rx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind hostfifo_port hostfifo_port_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_out(bus_out),
  .avail_n(avail_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rd_pop(rd_pop),
  .wr_fall(wr_fall), .wr_overflow(wr_overflow), .flush_req(flush_req),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/hostfifo_port_tb.sv
module hostfifo_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int HOLD  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd_n = 1'b1, host_wr_n = 1'b1, host_flush_n = 1'b1;
  logic [7:0] bus_in = '0, in_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] bus_out, out_data;
  logic bus_oe, avail_n, space_n, wr_overflow, in_ready, out_valid, flush_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostfifo_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_flush_n(host_flush_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .avail_n(avail_n), .space_n(space_n),
    .wr_overflow(wr_overflow), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .flush_req(flush_req)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [7:0] mrx[$];
  logic [7:0] mtx[$];
  logic s1r = 1, s2r = 1, dr = 1, s1w = 1, s2w = 1, dw = 1, s1f = 1, s2f = 1, df = 1;
  int mhold = 0;
  logic movf = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      automatic logic rr = s2r & ~dr;
      automatic logic wf = ~s2w & dw;
      automatic bit rx_ok = mrx.size() < DEPTH;
      automatic bit rx_pop = rr && mrx.size() > 0;
      automatic int tx_n = mtx.size();
      automatic bit tx_pop = tx_n > 0 && out_ready;
      if (rx_pop) void'(mrx.pop_front());
      if (in_valid && rx_ok) mrx.push_back(in_data);
      if (rr) mhold = HOLD;
      else if (mhold > 0) mhold--;
      if (tx_pop) void'(mtx.pop_front());
      if (wf) begin
        if (tx_n == DEPTH) movf = 1;
        else mtx.push_back(bus_in);
      end
      dr = s2r; s2r = s1r; s1r = host_rd_n;
      dw = s2w; s2w = s1w; s1w = host_wr_n;
      df = s2f; s2f = s1f; s1f = host_flush_n;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk("R1 bus_oe", bus_oe, rst_n & ~host_rd_n);
    if (bus_oe && mrx.size() > 0) chk("R1 bus_out", bus_out, mrx[0]);
    chk("R2 R4 avail_n", avail_n, !rst_n || mrx.size() == 0 || mhold > 0);
    chk("R5 space_n", space_n, !rst_n || mtx.size() == DEPTH);
    chk("R7 wr_overflow", wr_overflow, movf);
    chk("R8 flush_req", flush_req, rst_n && !s2f && df);
    chk("R10 in_ready", in_ready, mrx.size() < DEPTH);
    chk("R11 out_valid", out_valid, mtx.size() > 0);
    if (mtx.size() > 0) chk("R6 R11 out_data", out_data, mtx[0]);
    if (!rst_n) chk("R9 reset flags", {avail_n, space_n, bus_oe, flush_req}, 8'b1100);
  end

  task automatic push_up(logic [7:0] d);
    @(negedge clk); in_data = d; in_valid = 1;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic host_read();
    @(negedge clk); host_rd_n = 0;
    repeat (4) @(negedge clk);
    host_rd_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_write(logic [7:0] d);
    @(negedge clk); bus_in = d;
    @(negedge clk); host_wr_n = 0;
    repeat (4) @(negedge clk);
    host_wr_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R10 R3 R4: queued bytes read out in order, empty read ignored
    push_up(8'hA1); push_up(8'hB2); push_up(8'hC3);
    repeat (3) @(negedge clk);
    host_read(); host_read(); host_read();
    host_read();
    // R6 R5 R7: fill the host-write queue, then one more
    for (int i = 0; i < DEPTH + 1; i++) host_write(8'h40 + 8'(i));
    repeat (3) @(negedge clk);
    out_ready = 1;
    repeat (DEPTH + 4) @(negedge clk);
    out_ready = 0;
    host_write(8'h5A);
    // R10: fill host-read queue past capacity
    for (int i = 0; i < DEPTH + 1; i++) push_up(8'h10 + 8'(i));
    host_read(); host_read();
    // R8: flush strobe
    @(negedge clk); host_flush_n = 0;
    repeat (5) @(negedge clk); host_flush_n = 1;
    repeat (4) @(negedge clk);
    // R1 R3: push during a read
    @(negedge clk); host_rd_n = 0;
    push_up(8'hEE);
    repeat (3) @(negedge clk); host_rd_n = 1;
    repeat (8) @(negedge clk);
    out_ready = 1;
    repeat (6) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=done", cycles);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule